// File: doc/BRIEF.md
# Two-Slot Transmit Byte Buffer

This block sits between a register-write port and a serial shift engine on the transmit side of a two-wire bus controller. Software pushes either one byte or a pair of bytes in a single write. The engine takes bytes from the head one at a time and reports when it has finished shifting one out. Nothing else lies on this path.

The block reports how many bytes it holds. It also keeps a level flag whose threshold is chosen by a mode input: in one mode the flag tracks emptiness, and in the other it carries hysteresis between full and not-full. It emits one-cycle pulses when the level flag sets and when a write is refused. A sticky done indication shows that the engine has finished and nothing remains. A clear command drops everything that is stored.

Top module: `tx_pair_buffer`

## Requirements
- R1: After reset `fill_count` is 0, `head_valid` is 0, `level_flag` is 1, and `level_pulse`, `ovf_pulse` and `tx_done` are 0.
- R2: `wr_single` stores `wr_data[7:0]` as one entry. Entries leave in arrival order, and `head_data` shows the oldest stored byte whenever `head_valid` is 1.
- R3: `wr_double` stores `wr_data[7:0]` and then `wr_data[15:8]` as two entries, with the low byte older. When both write strobes are high, the double write is the one performed.
- R4: The buffer holds at most 2 bytes. `fill_count` reports 0, 1 or 2, and `head_valid` is 1 exactly when `fill_count` is non-zero. A `pop` while empty has no effect.
- R5: A write needs 1 or 2 slots. The free room is 2 minus the count, plus 1 if a valid pop happens in the same cycle. When the need exceeds the room, nothing is stored, and `ovf_pulse` is 1 for exactly the cycle after that write. A double write is all-or-nothing.
- R6: `clear` empties the buffer in one cycle. It overrides any write or pop in the same cycle, and it raises no overflow.
- R7: With `level_half`=0, `level_flag` is 1 exactly when the buffer is empty.
- R8: With `level_half`=1, `level_flag` goes to 0 when the buffer becomes full. It goes to 1 when the count leaves 2 (through a pop or a clear). Otherwise it holds.
- R9: `level_pulse` is high for the single cycle in which `level_flag` rises from 0 to 1, and never while the flag merely stays at 1.
- R10: `tx_done` sets when `byte_done` is high in a cycle that leaves the buffer empty. An accepted write clears it, and otherwise it holds.
- R11: A write and a valid pop in the same cycle change the count by the net amount, and the popped byte is the oldest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_single | input | 1 | Push the low byte of `wr_data` |
| wr_double | input | 1 | Push both bytes of `wr_data`, low byte first |
| wr_data | input | 16 | Write data (2 x DATA_W) |
| clear | input | 1 | Discard all stored bytes |
| pop | input | 1 | Engine takes the head byte |
| byte_done | input | 1 | Engine finished shifting a byte |
| level_half | input | 1 | Level threshold: 0 = empty, 1 = half-full hysteresis |
| head_data | output | 8 | Oldest stored byte |
| head_valid | output | 1 | A byte is available |
| fill_count | output | 2 | Number of stored bytes |
| level_flag | output | 1 | Level indication |
| level_pulse | output | 1 | One-cycle pulse when the level flag sets |
| ovf_pulse | output | 1 | One-cycle pulse after a refused write |
| tx_done | output | 1 | Engine done and buffer empty |

## Verification
The bench builds the block at its default 8-bit byte width, which puts both halves of the 16-bit write word and the pointer wrap of the two-slot store within reach. Directed sequences reach every count transition under both level modes. They also cover write-plus-pop at full and at one entry, both strobes together, and clear during a write. A long stretch of random strobes then mixes pops, clears and mode flips against the queue model.

// File: rtl/txpb_pkg.sv
package txpb_pkg;
  localparam int SLOTS = 2;
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
endpackage

// File: rtl/txpb_admit.sv
module txpb_admit
  import txpb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_single,
  input  logic             wr_double,
  input  logic             pop_req,
  input  logic             clear,
  output logic             push_one,
  output logic             push_two,
  output logic             pop_en,
  output logic             accepted,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             ovf_q
);
  logic [CNT_W:0] need;
  logic [CNT_W:0] room;
  logic           refuse;
  logic           ovf_d;

  always_comb begin
    pop_en   = pop_req && (cnt_q != '0) && !clear;
    need     = wr_double ? (CNT_W+1)'(2) : (wr_single ? (CNT_W+1)'(1) : '0);
    room     = (CNT_W+1)'(SLOTS) - {1'b0, cnt_q} + {{CNT_W{1'b0}}, pop_en};
    accepted = !clear && (need != '0) && (need <= room);
    refuse   = !clear && (need != '0) && (need > room);
    push_two = accepted && wr_double;
    push_one = accepted && !wr_double;
    ovf_d    = refuse;
    if (clear) begin
      cnt_d = '0;
    end else begin
      cnt_d = CNT_W'({1'b0, cnt_q} + (accepted ? need : '0)
                     - {{CNT_W{1'b0}}, pop_en});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/txpb_store.sv
module txpb_store
  import txpb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                pop_en,
  input  logic                push_one,
  input  logic                push_two,
  input  logic [2*DATA_W-1:0] din,
  output logic [DATA_W-1:0]   head
);
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d, wr_nx;
  logic [DATA_W-1:0] slot_q [SLOTS];

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_nx = step_ptr(wr_q);
    if (clear) begin
      wr_d = '0;
      rd_d = '0;
    end else begin
      wr_d = push_two ? step_ptr(wr_nx) : (push_one ? wr_nx : wr_q);
      rd_d = pop_en ? step_ptr(rd_q) : rd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic we_lo, we_hi;
    assign we_lo = (push_one || push_two) && (wr_q == PTR_W'(i));
    assign we_hi = push_two && (wr_nx == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (we_lo) begin
        slot_q[i] <= din[DATA_W-1:0];
      end else if (we_hi) begin
        slot_q[i] <= din[2*DATA_W-1:DATA_W];
      end
    end
  end

  assign head = slot_q[rd_q];
endmodule

// File: rtl/txpb_level.sv
module txpb_level
  import txpb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic             half_mode,
  input  logic             byte_done,
  input  logic             accepted,
  output logic             flag_q,
  output logic             pulse_q,
  output logic             done_q
);
  logic flag_d, pulse_d, done_d;

  always_comb begin
    if (!half_mode) begin
      flag_d = (cnt_d == '0);
    end else if (cnt_d == CNT_W'(SLOTS)) begin
      flag_d = 1'b0;
    end else if (cnt_q == CNT_W'(SLOTS)) begin
      flag_d = 1'b1;
    end else begin
      flag_d = flag_q;
    end
    pulse_d = flag_d && !flag_q;
    if (byte_done && (cnt_d == '0)) begin
      done_d = 1'b1;
    end else if (accepted) begin
      done_d = 1'b0;
    end else begin
      done_d = done_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b1;
      pulse_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/tx_pair_buffer.sv
module tx_pair_buffer
  import txpb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_single,
  input  logic                wr_double,
  input  logic [2*DATA_W-1:0] wr_data,
  input  logic                clear,
  input  logic                pop,
  input  logic                byte_done,
  input  logic                level_half,
  output logic [DATA_W-1:0]   head_data,
  output logic                head_valid,
  output logic [CNT_W-1:0]    fill_count,
  output logic                level_flag,
  output logic                level_pulse,
  output logic                ovf_pulse,
  output logic                tx_done
);
  logic             push_one, push_two, pop_en, accepted;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  txpb_admit u_admit (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_single(wr_single),
    .wr_double(wr_double),
    .pop_req  (pop),
    .clear    (clear),
    .push_one (push_one),
    .push_two (push_two),
    .pop_en   (pop_en),
    .accepted (accepted),
    .cnt_q    (cnt_q),
    .cnt_d    (cnt_d),
    .ovf_q    (ovf_pulse)
  );

  txpb_store #(.DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .pop_en  (pop_en),
    .push_one(push_one),
    .push_two(push_two),
    .din     (wr_data),
    .head    (head_data)
  );

  txpb_level u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_q    (cnt_q),
    .cnt_d    (cnt_d),
    .half_mode(level_half),
    .byte_done(byte_done),
    .accepted (accepted),
    .flag_q   (level_flag),
    .pulse_q  (level_pulse),
    .done_q   (tx_done)
  );

  assign fill_count = cnt_q;
  assign head_valid = (cnt_q != '0);
endmodule

// File: rtl/tx_pair_buffer_chk.sv
module tx_pair_buffer_chk
  import txpb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_single,
  input logic                wr_double,
  input logic                clear,
  input logic                pop,
  input logic                level_half,
  input logic [CNT_W-1:0]    fill_count,
  input logic                level_flag,
  input logic                level_pulse,
  input logic                ovf_pulse,
  input logic                tx_done
);
  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CNT_W'(SLOTS));

  // R5
  full_double_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_double && fill_count == CNT_W'(SLOTS) && !clear) |=> ovf_pulse);

  // R5
  empty_single_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_single && !wr_double && fill_count == '0 && !clear)
      |=> (!ovf_pulse && fill_count == CNT_W'(1)));

  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (fill_count == '0 && !ovf_pulse));

  // R7
  empty_mode_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_half && $past(!level_half)) |-> (level_flag == (fill_count == '0)));

  // R9
  level_pulse_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_pulse |-> (level_flag && !$past(level_flag)));

  // R10
  done_means_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (fill_count == '0));
endmodule

bind tx_pair_buffer tx_pair_buffer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_single  (wr_single),
  .wr_double  (wr_double),
  .clear      (clear),
  .pop        (pop),
  .level_half (level_half),
  .fill_count (fill_count),
  .level_flag (level_flag),
  .level_pulse(level_pulse),
  .ovf_pulse  (ovf_pulse),
  .tx_done    (tx_done)
);

// File: tb/tx_pair_buffer_test.sv
module tx_pair_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_single, wr_double, clear, pop, byte_done, level_half;
  logic [2*DW-1:0] wr_data;
  logic [DW-1:0] head_data;
  logic          head_valid, level_flag, level_pulse, ovf_pulse, tx_done;
  logic [1:0]    fill_count;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  byte unsigned mq[$];
  bit m_flag, m_pulse, m_ovf, m_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_pair_buffer #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_single(wr_single), .wr_double(wr_double),
    .wr_data(wr_data), .clear(clear), .pop(pop), .byte_done(byte_done),
    .level_half(level_half), .head_data(head_data), .head_valid(head_valid),
    .fill_count(fill_count), .level_flag(level_flag), .level_pulse(level_pulse),
    .ovf_pulse(ovf_pulse), .tx_done(tx_done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    check({tag, " count"}, int'(fill_count), mq.size());
    check("R4 head_valid", int'(head_valid), int'(mq.size() > 0));
    if (mq.size() > 0) check({tag, " head"}, int'(head_data), int'(mq[0]));
    check(level_half ? "R8 level_flag" : "R7 level_flag", int'(level_flag), int'(m_flag));
    check("R9 level_pulse", int'(level_pulse), int'(m_pulse));
    check("R5 ovf_pulse", int'(ovf_pulse), int'(m_ovf));
    check("R10 tx_done", int'(tx_done), int'(m_done));
  endtask

  task automatic step(input bit ws, input bit wd, input logic [15:0] d,
                      input bit p, input bit clr, input bit bd, input bit hm,
                      input string tag);
    int oldc, need, room, newc;
    bit pe, acc, nf;
    @(negedge clk);
    wr_single = ws; wr_double = wd; wr_data = d; pop = p;
    clear = clr; byte_done = bd; level_half = hm;
    oldc = mq.size();
    pe = p && oldc > 0 && !clr;
    need = wd ? 2 : (ws ? 1 : 0);
    room = 2 - oldc + int'(pe);
    acc = 0; m_ovf = 0;
    if (clr) begin
      mq.delete();
    end else begin
      if (pe) void'(mq.pop_front());
      if (need > 0 && need <= room) begin
        acc = 1;
        mq.push_back(d[7:0]);
        if (wd) mq.push_back(d[15:8]);
      end else if (need > 0) begin
        m_ovf = 1;
      end
    end
    newc = mq.size();
    if (!hm) nf = (newc == 0);
    else if (newc == 2) nf = 0;
    else if (oldc == 2) nf = 1;
    else nf = m_flag;
    m_pulse = nf && !m_flag;
    m_flag = nf;
    if (bd && newc == 0) m_done = 1;
    else if (acc) m_done = 0;
    @(posedge clk);
    #1;
    compare_all(tag);
  endtask

  task automatic idle(input bit hm);
    step(0, 0, 16'h0, 0, 0, 0, hm, "R4");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0;
    wr_single = 0; wr_double = 0; wr_data = '0; clear = 0; pop = 0;
    byte_done = 0; level_half = 0;
    m_flag = 1; m_pulse = 0; m_ovf = 0; m_done = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 count", int'(fill_count), 0);
    check("R1 head_valid", int'(head_valid), 0);
    check("R1 level_flag", int'(level_flag), 1);
    check("R1 level_pulse", int'(level_pulse), 0);
    check("R1 ovf_pulse", int'(ovf_pulse), 0);
    check("R1 tx_done", int'(tx_done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(0);

    // R2 single push and pop order
    step(1, 0, 16'h99AA, 0, 0, 0, 0, "R2");
    step(1, 0, 16'h77BB, 0, 0, 0, 0, "R2");
    step(0, 0, 16'h0, 1, 0, 0, 0, "R2");
    check("R2 second byte at head", int'(head_data), 8'hBB);
    step(0, 0, 16'h0, 1, 0, 0, 0, "R2");
    idle(0);

    // R3 double write order, and priority over single
    step(0, 1, 16'h2211, 0, 0, 0, 0, "R3");
    check("R3 low byte first", int'(head_data), 8'h11);
    step(0, 0, 16'h0, 1, 0, 0, 0, "R3");
    check("R3 high byte second", int'(head_data), 8'h22);
    step(0, 0, 16'h0, 1, 0, 0, 0, "R3");
    step(1, 1, 16'h4433, 0, 0, 0, 0, "R3");
    check("R3 both strobes give two bytes", int'(fill_count), 2);

    // R5 overflow when full, double with one free slot
    step(1, 0, 16'h0055, 0, 0, 0, 0, "R5");
    step(0, 0, 16'h0, 1, 0, 0, 0, "R5");
    step(0, 1, 16'h6655, 0, 0, 0, 0, "R5");
    check("R5 refused double stores nothing", int'(fill_count), 1);
    idle(0);

    // R11 write plus pop, at one entry and at full
    step(0, 1, 16'h8877, 1, 0, 0, 0, "R11");
    check("R11 head after double+pop", int'(head_data), 8'h77);
    step(1, 0, 16'h00CC, 1, 0, 0, 0, "R11");
    check("R11 full+pop+single count", int'(fill_count), 2);
    check("R11 oldest left", int'(head_data), 8'h88);

    // R6 clear dominates a write
    step(0, 1, 16'hEEDD, 1, 1, 0, 0, "R6");
    check("R6 cleared", int'(fill_count), 0);
    // R4 pop when empty
    step(0, 0, 16'h0, 1, 0, 0, 0, "R4");

    // R10 tx_done
    step(1, 0, 16'h0031, 0, 0, 0, 0, "R10");
    step(0, 0, 16'h0, 1, 0, 1, 0, "R10");
    check("R10 done set", int'(tx_done), 1);
    idle(0);
    step(1, 0, 16'h0032, 0, 0, 0, 0, "R10");
    check("R10 done cleared by write", int'(tx_done), 0);
    step(0, 0, 16'h0, 1, 0, 0, 0, "R10");

    // R8 half mode hysteresis
    step(1, 0, 16'h0041, 0, 0, 0, 1, "R8");
    step(1, 0, 16'h0042, 0, 0, 0, 1, "R8");
    check("R8 flag low at full", int'(level_flag), 0);
    step(0, 0, 16'h0, 1, 0, 0, 1, "R8");
    check("R8 flag set on leaving full", int'(level_flag), 1);
    check("R9 pulse on set", int'(level_pulse), 1);
    step(1, 0, 16'h0043, 0, 0, 0, 1, "R8");
    step(0, 0, 16'h0, 1, 0, 0, 1, "R8");
    step(0, 0, 16'h0, 1, 0, 0, 1, "R8");
    step(0, 1, 16'h4544, 0, 0, 0, 1, "R8");
    step(0, 0, 16'h0, 0, 1, 0, 1, "R8");
    idle(1);

    // mixed random stimulus against the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1] & r[2], r[23:8], r[3] | r[4], (r[7:5] == 3'b000),
           r[24], r[25] & r[26] & r[27], "R11");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule